// File: doc/BRIEF.md
# Single-Flag Compare and Conditional Branch Unit

This block holds one true/false status bit for a processor core. Compare operations evaluate a relation between a register and either a second register or a short immediate, and write the outcome into the bit. Two conditional branches read it. The branch-if-true form is taken when the bit is set. The branch-if-false form is taken when the bit is clear. Each branch also produces its PC-relative target.

The core offers only a small set of relations. These are equality, signed greater and greater-or-equal, and unsigned higher and higher-or-same. Inverse tests such as not-equal, less, and less-or-equal come from picking the opposite branch sense. No other operation writes the bit, so a test result survives across the body of a then/else block.

Operation code `op_i` has four values: 0 is any other operation, 1 is compare, 2 is branch-if-true and 3 is branch-if-false. Compare kind `kind_i` has five valid values: 0 equal, 1 signed greater, 2 signed greater-or-equal, 3 unsigned higher, 4 unsigned higher-or-same. Codes 5 to 7 are undefined. `form_imm_i` is 0 for the register-register form and 1 for the immediate form.

Top module: `cmp_flag_br_unit`

## Requirements
- R1: After reset the status bit `flag_o` is 0.
- R2: Kind 0 (equal) sets the bit to 1 when the register operand equals the second operand, and to 0 otherwise.
- R3: Kind 1 sets the bit when the register operand is greater than the second operand, both taken as two's-complement values.
- R4: Kind 2 sets the bit when the register operand is greater than or equal to the second operand, both taken as two's-complement values.
- R5: Kind 3 sets the bit when the register operand is greater than the second operand, both taken as unsigned values.
- R6: Kind 4 sets the bit when the register operand is greater than or equal to the second operand, both taken as unsigned values.
- R7: In the immediate form, the second operand is `imm_i` (10 bits) sign-extended to the operand width, for signed and unsigned kinds alike. The relation is tested as "register kind immediate".
- R8: The register form accepts only kinds 0, 1 and 3; the immediate form accepts kinds 0 to 4. A valid compare with any other kind/form pair drives `illegal_o` high in the same cycle and leaves the bit unchanged. Accepted compares keep `illegal_o` low.
- R9: Operations with `op_i` of 0, 2 or 3, and any cycle with `valid_i` low, leave the bit unchanged.
- R10: `taken_o` is 1 for a valid branch-if-true when the bit is 1, and for a valid branch-if-false when the bit is 0. It is 0 in every other case.
- R11: `target_o` equals `pc_i` plus twice the sign-extended 20-bit `disp_i`, modulo 2^PC_W.
- R12: A compare updates the bit at the clock edge that ends its cycle. A branch in the following cycle sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 2 | Operation class: 0 other, 1 compare, 2 branch-if-true, 3 branch-if-false |
| kind_i | input | 3 | Compare kind code |
| form_imm_i | input | 1 | 1 selects the immediate form |
| rs_a_i | input | XLEN | Register operand |
| rs_b_i | input | XLEN | Second register operand |
| imm_i | input | IMM_W | Immediate operand |
| pc_i | input | PC_W | Address of the branch |
| disp_i | input | DISP_W | Branch displacement in 16-bit units |
| flag_o | output | 1 | Status bit |
| taken_o | output | 1 | Branch taken |
| target_o | output | PC_W | Branch target address |
| illegal_o | output | 1 | Unsupported compare kind/form |

## Verification
The assertions check the following on every cycle:
- The bit holds through non-compare and illegal operations.
- The illegal flag is raised only on compares and never on accepted register-form kinds.
- A branch follows the bit with the correct sense.
- Register equal, register signed-greater and immediate-equal compares land in the bit one edge later.

The bench scenarios cover the rest:
- The full arithmetic of every kind at the sign and carry boundaries, in both forms, across every immediate value.
- The held value across a run of other operations.
- The wrap-around of branch targets.

// File: rtl/cfb_pkg.sv
package cfb_pkg;
  typedef enum logic [1:0] {
    OP_OTHER = 2'd0,
    OP_CMP   = 2'd1,
    OP_BT    = 2'd2,
    OP_BF    = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    K_EQ = 3'd0,
    K_GT = 3'd1,
    K_GE = 3'd2,
    K_HI = 3'd3,
    K_HS = 3'd4
  } kind_e;
endpackage

// File: rtl/cfb_decode.sv
module cfb_decode
  import cfb_pkg::*;
(
  input  logic       valid_i,
  input  logic [1:0] op_i,
  input  logic [2:0] kind_i,
  input  logic       form_imm_i,
  output logic       cmp_wr_o,
  output logic       illegal_o,
  output logic       is_bt_o,
  output logic       is_bf_o
);
  logic kind_ok;
  logic is_cmp;

  always_comb begin
    kind_ok = 1'b0;
    case (kind_i)
      K_EQ, K_GT, K_HI: kind_ok = 1'b1;
      K_GE, K_HS:       kind_ok = form_imm_i; // immediate form only
      default:          kind_ok = 1'b0;
    endcase
  end

  assign is_cmp    = valid_i && (op_i == OP_CMP);
  assign cmp_wr_o  = is_cmp && kind_ok;
  assign illegal_o = is_cmp && !kind_ok;
  assign is_bt_o   = valid_i && (op_i == OP_BT);
  assign is_bf_o   = valid_i && (op_i == OP_BF);
endmodule

// File: rtl/cfb_compare.sv
module cfb_compare
  import cfb_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 10
) (
  input  logic [XLEN-1:0]  rs_a_i,
  input  logic [XLEN-1:0]  rs_b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             form_imm_i,
  input  logic [2:0]       kind_i,
  output logic             result_o
);
  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] opb;
  logic [XLEN:0]   sum;
  logic [XLEN-1:0] diff;
  logic            carry, ovf;
  logic            eq, uge, ugt, slt, sge, sgt;

  if (XLEN > IMM_W) begin : g_ext
    assign imm_ext = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  end else begin : g_trunc
    assign imm_ext = imm_i[XLEN-1:0];
  end

  assign opb = form_imm_i ? imm_ext : rs_b_i;

  // single subtractor serves all relations: a + ~b + 1
  assign sum   = {1'b0, rs_a_i} + {1'b0, ~opb} + {{XLEN{1'b0}}, 1'b1};
  assign diff  = sum[XLEN-1:0];
  assign carry = sum[XLEN];
  assign ovf   = (rs_a_i[XLEN-1] ^ opb[XLEN-1]) & (rs_a_i[XLEN-1] ^ diff[XLEN-1]);

  assign eq  = (diff == '0);
  assign uge = carry;
  assign ugt = uge & ~eq;
  assign slt = diff[XLEN-1] ^ ovf;
  assign sge = ~slt;
  assign sgt = sge & ~eq;

  always_comb begin
    case (kind_i)
      K_EQ:    result_o = eq;
      K_GT:    result_o = sgt;
      K_GE:    result_o = sge;
      K_HI:    result_o = ugt;
      K_HS:    result_o = uge;
      default: result_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfb_flag.sv
module cfb_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_val_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_o <= 1'b0;
    else if (wr_en_i) flag_o <= wr_val_i;
  end
endmodule

// File: rtl/cfb_branch.sv
module cfb_branch #(
  parameter int PC_W   = 48,
  parameter int DISP_W = 20
) (
  input  logic              is_bt_i,
  input  logic              is_bf_i,
  input  logic              flag_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              taken_o,
  output logic [PC_W-1:0]   target_o
);
  localparam int EXT_W = PC_W - DISP_W - 1;

  logic [PC_W-1:0] offs;

  // displacement counts 16-bit units
  if (EXT_W > 0) begin : g_ext
    assign offs = {{EXT_W{disp_i[DISP_W-1]}}, disp_i, 1'b0};
  end else begin : g_trunc
    assign offs = {disp_i[PC_W-2:0], 1'b0};
  end

  assign target_o = pc_i + offs;
  assign taken_o  = (is_bt_i & flag_i) | (is_bf_i & ~flag_i);
endmodule

// File: rtl/cmp_flag_br_unit.sv
module cmp_flag_br_unit #(
  parameter int XLEN   = 64,
  parameter int IMM_W  = 10,
  parameter int PC_W   = 48,
  parameter int DISP_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [2:0]        kind_i,
  input  logic              form_imm_i,
  input  logic [XLEN-1:0]   rs_a_i,
  input  logic [XLEN-1:0]   rs_b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              flag_o,
  output logic              taken_o,
  output logic [PC_W-1:0]   target_o,
  output logic              illegal_o
);
  logic cmp_wr, is_bt, is_bf, cmp_res;

  cfb_decode u_dec (
    .valid_i    (valid_i),
    .op_i       (op_i),
    .kind_i     (kind_i),
    .form_imm_i (form_imm_i),
    .cmp_wr_o   (cmp_wr),
    .illegal_o  (illegal_o),
    .is_bt_o    (is_bt),
    .is_bf_o    (is_bf)
  );

  cfb_compare #(.XLEN(XLEN), .IMM_W(IMM_W)) u_cmp (
    .rs_a_i     (rs_a_i),
    .rs_b_i     (rs_b_i),
    .imm_i      (imm_i),
    .form_imm_i (form_imm_i),
    .kind_i     (kind_i),
    .result_o   (cmp_res)
  );

  cfb_flag u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (cmp_wr),
    .wr_val_i (cmp_res),
    .flag_o   (flag_o)
  );

  cfb_branch #(.PC_W(PC_W), .DISP_W(DISP_W)) u_br (
    .is_bt_i  (is_bt),
    .is_bf_i  (is_bf),
    .flag_i   (flag_o),
    .pc_i     (pc_i),
    .disp_i   (disp_i),
    .taken_o  (taken_o),
    .target_o (target_o)
  );
endmodule

// File: rtl/cfb_checker.sv
module cfb_checker #(
  parameter int XLEN   = 64,
  parameter int IMM_W  = 10,
  parameter int PC_W   = 48,
  parameter int DISP_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        op_i,
  input logic [2:0]        kind_i,
  input logic              form_imm_i,
  input logic [XLEN-1:0]   rs_a_i,
  input logic [XLEN-1:0]   rs_b_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic              flag_o,
  input logic              taken_o,
  input logic              illegal_o
);
  logic cmp_now, reg_now, imm_now;
  logic [XLEN-1:0] imm_sx;
  assign cmp_now = valid_i && (op_i == 2'd1);
  assign reg_now = cmp_now && !form_imm_i;
  assign imm_now = cmp_now && form_imm_i;
  assign imm_sx  = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};

  a_r9_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_now |=> $stable(flag_o));

  a_r8_illegal_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> $stable(flag_o));

  a_r8_illegal_only_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> cmp_now);

  a_r8_reg_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_now && (kind_i == 3'd0 || kind_i == 3'd1 || kind_i == 3'd3)) |-> !illegal_o);

  a_r10_bt_sense: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd2) |-> (taken_o == flag_o));

  a_r10_bf_sense: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd3) |-> (taken_o == !flag_o));

  a_r10_no_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && op_i[1]) |-> !taken_o);

  a_r2_reg_eq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_now && kind_i == 3'd0) |=> (flag_o == ($past(rs_a_i) == $past(rs_b_i))));

  a_r3_reg_gt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_now && kind_i == 3'd1) |=>
      (flag_o == ($signed($past(rs_a_i)) > $signed($past(rs_b_i)))));

  a_r7_imm_eq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imm_now && kind_i == 3'd0) |=> (flag_o == ($past(rs_a_i) == $past(imm_sx))));
endmodule

bind cmp_flag_br_unit cfb_checker #(
  .XLEN(XLEN), .IMM_W(IMM_W), .PC_W(PC_W), .DISP_W(DISP_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .op_i       (op_i),
  .kind_i     (kind_i),
  .form_imm_i (form_imm_i),
  .rs_a_i     (rs_a_i),
  .rs_b_i     (rs_b_i),
  .imm_i      (imm_i),
  .flag_o     (flag_o),
  .taken_o    (taken_o),
  .illegal_o  (illegal_o)
);

// File: tb/cmp_flag_br_unit_tb.sv
`timescale 1ns/1ps
module cmp_flag_br_unit_tb;
  localparam int XLEN = 16, IMM_W = 10, PC_W = 32, DISP_W = 20;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic valid_i = 1'b0, form_imm_i = 1'b0;
  logic [1:0] op_i = 2'd0;
  logic [2:0] kind_i = 3'd0;
  logic [XLEN-1:0] rs_a_i = '0, rs_b_i = '0;
  logic [IMM_W-1:0] imm_i = '0;
  logic [PC_W-1:0] pc_i = '0;
  logic [DISP_W-1:0] disp_i = '0;
  logic flag_o, taken_o, illegal_o;
  logic [PC_W-1:0] target_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmp_flag_br_unit #(.XLEN(XLEN), .IMM_W(IMM_W), .PC_W(PC_W), .DISP_W(DISP_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .kind_i(kind_i),
    .form_imm_i(form_imm_i), .rs_a_i(rs_a_i), .rs_b_i(rs_b_i), .imm_i(imm_i),
    .pc_i(pc_i), .disp_i(disp_i), .flag_o(flag_o), .taken_o(taken_o),
    .target_o(target_o), .illegal_o(illegal_o));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic ref_cmp(input int k, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    case (k)
      0: return a == b;
      1: return $signed(a) > $signed(b);
      2: return $signed(a) >= $signed(b);
      3: return a > b;
      default: return a >= b;
    endcase
  endfunction

  function automatic string kreq(input int k);
    case (k)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  // called at a negedge; returns at the next negedge
  task automatic do_cmp(input bit fimm, input int k, input logic [XLEN-1:0] a,
                        input logic [XLEN-1:0] b, input logic [IMM_W-1:0] im);
    logic old, exp;
    logic [XLEN-1:0] opb;
    opb = fimm ? {{(XLEN-IMM_W){im[IMM_W-1]}}, im} : b;
    exp = ref_cmp(k, a, opb);
    old = flag_o;
    valid_i = 1; op_i = 2'd1; kind_i = 3'(k); form_imm_i = fimm;
    rs_a_i = a; rs_b_i = b; imm_i = im;
    #1;
    check("R8 legal", illegal_o, 0);
    check("R12 pre-edge", flag_o, old);
    @(negedge clk);
    check(fimm ? {kreq(k), " R7"} : kreq(k), flag_o, exp);
  endtask

  task automatic do_illegal(input bit fimm, input int k);
    logic old;
    old = flag_o;
    valid_i = 1; op_i = 2'd1; kind_i = 3'(k); form_imm_i = fimm;
    rs_a_i = old ? 16'h0001 : 16'h0000; rs_b_i = old ? 16'h0000 : 16'h0000;
    imm_i = '0;
    #1;
    check("R8 illegal raised", illegal_o, 1);
    @(negedge clk);
    check("R8 flag kept", flag_o, old);
  endtask

  task automatic set_flag(input logic v);
    do_cmp(0, 0, 16'h1234, v ? 16'h1234 : 16'h4321, '0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset flag", flag_o, 0);
    rst_ni = 1;
    @(negedge clk);
    check("R1 after release", flag_o, 0);
    check("R10 idle not taken", taken_o, 0);

    // register form sweep
    for (int i = 0; i < 256; i++) begin
      logic [XLEN-1:0] a;
      logic [XLEN-1:0] bl [8];
      a = {i[7:0], i[7:0]} ^ {i[3:0], 12'h000};
      bl[0] = a; bl[1] = a + 1; bl[2] = a - 1; bl[3] = 16'h0000;
      bl[4] = 16'h7fff; bl[5] = 16'h8000; bl[6] = 16'hffff; bl[7] = a ^ 16'h8000;
      for (int j = 0; j < 8; j++) begin
        do_cmp(0, 0, a, bl[j], '0);
        do_cmp(0, 1, a, bl[j], '0);
        do_cmp(0, 3, a, bl[j], '0);
      end
    end

    // immediate form sweep over every immediate
    for (int m = 0; m < 1024; m++) begin
      logic [IMM_W-1:0] im;
      logic [XLEN-1:0] s;
      logic [XLEN-1:0] al [8];
      im = m[IMM_W-1:0];
      s = {{(XLEN-IMM_W){im[IMM_W-1]}}, im};
      al[0] = s; al[1] = s + 1; al[2] = s - 1; al[3] = 16'h0000;
      al[4] = 16'h7fff; al[5] = 16'h8000; al[6] = 16'hffff; al[7] = 16'h0155;
      for (int j = 0; j < 8; j++)
        for (int k = 0; k < 5; k++)
          do_cmp(1, k, al[j], 16'h5a5a, im);
    end

    // illegal combinations
    for (int v = 0; v < 2; v++) begin
      set_flag(v[0]);
      do_illegal(0, 2); do_illegal(0, 4);
      for (int k = 5; k < 8; k++) begin
        do_illegal(0, k); do_illegal(1, k);
      end
    end

    // hold across non-compare operations
    for (int v = 0; v < 2; v++) begin
      set_flag(v[0]);
      for (int n = 0; n < 12; n++) begin
        valid_i = (n % 4) != 3;
        op_i = valid_i ? 2'(n % 4 == 0 ? 0 : (n % 4 == 1 ? 2 : 3)) : 2'd1;
        kind_i = 3'd0; form_imm_i = 0;
        rs_a_i = 16'h00aa; rs_b_i = v[0] ? 16'h0055 : 16'h00aa;
        @(negedge clk);
        check("R9 flag held", flag_o, v[0]);
      end
    end

    // branches
    for (int v = 0; v < 2; v++) begin
      logic [DISP_W-1:0] dl [5];
      logic [PC_W-1:0] pl [2];
      dl[0] = 20'h00000; dl[1] = 20'h00001; dl[2] = 20'h7ffff;
      dl[3] = 20'h80000; dl[4] = 20'hfffff;
      pl[0] = 32'h0000_1000; pl[1] = 32'hffff_fff0;
      set_flag(v[0]);
      for (int p = 0; p < 2; p++)
        for (int d = 0; d < 5; d++) begin
          logic signed [PC_W-1:0] sd;
          logic [PC_W-1:0] exp_t;
          sd = {{(PC_W-DISP_W){dl[d][DISP_W-1]}}, dl[d]};
          exp_t = pl[p] + PC_W'(sd * 2);
          valid_i = 1; pc_i = pl[p]; disp_i = dl[d];
          op_i = 2'd2; #1;
          check("R10 BT", taken_o, v[0]);
          check("R11 target", target_o, exp_t);
          op_i = 2'd3; #1;
          check("R10 BF", taken_o, !v[0]);
          op_i = 2'd0; #1;
          check("R10 other", taken_o, 0);
          valid_i = 0; op_i = 2'd2; #1;
          check("R10 invalid", taken_o, 0);
          @(negedge clk);
          check("R9 branch keeps flag", flag_o, v[0]);
        end
    end

    // compare then branch in the next cycle
    valid_i = 1; op_i = 2'd1; kind_i = 3'd4; form_imm_i = 1;
    rs_a_i = 16'h0003; imm_i = 10'h3ff; // 3 >=u 0xffff -> 0
    @(negedge clk);
    op_i = 2'd3; #1;
    check("R12 BF after compare", taken_o, 1);
    @(negedge clk);
    valid_i = 0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule